// File: doc/BRIEF.md
# Buffered asynchronous serial transmitter with clear-to-send hold-off

This block sends characters on a single asynchronous serial line. Software, or a nearby controller, writes a character into a one-entry holding buffer. When the shift stage is free, the buffer contents move into the shift stage, which leaves the buffer free to accept the next character while the current frame is still on the line. A frame starts with a low start bit. Then come 8 or 9 data bits, least significant first, an optional even or odd parity bit, and one or two high stop bits. A programmable divisor sets the bit period. The divisor counts enable pulses from an external count-source strobe.

The same write port loads the frame format. Two status outputs report an empty buffer and an idle shift stage. A sticky interrupt request rises on one of two events, chosen by a configuration bit: the buffer handing its character to the shift stage, or the line going idle after the last stop bit. An acknowledge input clears the request.

Optional flow control pauses the link. When enabled, a synchronized clear-to-send line holds the next frame back at each frame boundary. A frame already on the line always runs to completion. A transmit-enable input gates frame starts in the same way.

Top module: `stx_core`

## Requirements
- R1: After reset, txd is high, buf_empty and shift_empty are 1, and irq is 0. While shift_empty is 1, txd stays high.
- R2: The bit period is 16 × (D + 1) cycles in which clk_en is high, where D is the divisor in wr_data[7:0] of a configuration write (wr_en with wr_cfg = 1). In a cycle with clk_en low, a frame on the line makes no progress.
- R3: A frame is a low start bit, then data bits D0 first, then the parity bit if enabled, then high stop bits. Configuration bit 8 selects 9 data bits (1) or 8 (0); with 9 bits, D8 follows D7. Bit 11 selects two stop bits (1) or one (0).
- R4: Bit 9 enables parity. Bit 10 selects odd parity (1) or even parity (0). The parity bit is computed over every data bit sent, including D8.
- R5: A data write (wr_en with wr_cfg = 0, character in wr_data[8:0]) clears buf_empty. When the character moves into the shift stage, buf_empty is set again. With the stage idle, the start bit is on txd after the second rising edge from the write. A character queued during a frame starts right after that frame's last stop bit, with no idle gap.
- R6: shift_empty is 0 from the start bit until the last stop bit ends with no character started, and 1 after that.
- R7: With bit 12 set, cts_line high holds off any new frame, both while idle and at a frame boundary. A frame already on the line finishes. After cts_line falls, the held frame's start bit is on txd after the third rising edge.
- R8: With bit 12 clear, cts_line has no effect, and a written character starts as in R5.
- R9: While tx_en is low, no new frame starts, but a frame on the line finishes. When tx_en rises, a waiting character starts at the next rising edge.
- R10: With bit 13 clear, irq is set at the edge where a character moves into the shift stage. With bit 13 set, irq is set at the edge where shift_empty rises. irq stays set until irq_ack is high at an edge, and a new event wins over an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Count-source strobe that advances the baud counter |
| wr_en | input | 1 | Write strobe |
| wr_cfg | input | 1 | 1: configuration write, 0: data write |
| wr_data | input | 14 | Write data: character, or divisor and format bits |
| tx_en | input | 1 | Allows new frames to start |
| cts_line | input | 1 | Asynchronous clear-to-send; high holds off frames |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | Shift stage is idle |
| irq | output | 1 | Sticky interrupt request |

## Verification
Each result has a fixed delay after its stimulus, and every check samples at that cycle, on the falling clock edge:

| Stimulus | Result | When it is due |
|---|---|---|
| Data write with the stage idle | Start bit on txd | Two rising edges after the write |
| Fall of cts_line | Start bit on txd | Three rising edges later (two synchronizer stages plus the load) |
| Rise of tx_en | Start bit on txd | One rising edge later |
| Start of a frame | Each line bit | Middle of its period, counted from the first falling edge that shows the start bit |
| Load, or end of the last stop bit | Interrupt flag | Same edge as the load or as the rise of shift_empty |

Back-to-back frames are measured as exactly half a bit period between the last stop-bit sample and the next start bit.

// File: rtl/stx_pkg.sv
package stx_pkg;
    localparam int DATA_MAX = 9;
    localparam int FRAME_W  = 1 + DATA_MAX + 1 + 2;
    localparam int LEFT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic irq_done;
        logic cts_en;
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic nine;
    } fmt_t;

    localparam int FMT_W = $bits(fmt_t);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [LEFT_W-1:0]  left;
        logic               busy;
    } shf_t;
endpackage

// File: rtl/stx_baud.sv
module stx_baud #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int OVS_W = $clog2(OVS);
    localparam int CNT_W = DIV_W + OVS_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        term  = {div, {OVS_W{1'b1}}};
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (clk_en) begin
            if (cnt_q >= term) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/stx_sync.sv
module stx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/stx_frame.sv
module stx_frame
    import stx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                tick,
    input  logic [DATA_MAX-1:0] data,
    input  fmt_t                fmt,
    output logic                txd,
    output logic                busy,
    output logic                frame_end
);
    shf_t st_d, st_q;

    logic [DATA_MAX-1:0] used;
    logic                par;
    logic [FRAME_W-1:0]  img;
    logic [LEFT_W-1:0]   len;

    always_comb begin
        used = data;
        if (!fmt.nine) used[DATA_MAX-1] = 1'b0;
        par = (^used) ^ fmt.par_odd;

        img      = '1;
        img[0]   = 1'b0;
        img[8:1] = data[7:0];
        if (fmt.nine) img[9] = data[8];
        if (fmt.par_en) begin
            if (fmt.nine) img[10] = par;
            else          img[9]  = par;
        end
        len = LEFT_W'(10) + LEFT_W'(fmt.nine) + LEFT_W'(fmt.par_en)
            + LEFT_W'(fmt.two_stop);

        frame_end = st_q.busy && tick && (st_q.left == LEFT_W'(1));

        st_d = st_q;
        if (load) begin
            st_d.shreg = img;
            st_d.left  = len;
            st_d.busy  = 1'b1;
        end else if (st_q.busy && tick) begin
            st_d.shreg = {1'b1, st_q.shreg[FRAME_W-1:1]};
            st_d.left  = st_q.left - LEFT_W'(1);
            if (frame_end) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg <= '1;
            st_q.left  <= '0;
            st_q.busy  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.busy ? st_q.shreg[0] : 1'b1;
    assign busy = st_q.busy;
endmodule

// File: rtl/stx_core.sv
module stx_core
    import stx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    localparam int WR_W       = DIV_W + FMT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic            wr_en,
    input  logic            wr_cfg,
    input  logic [WR_W-1:0] wr_data,
    input  logic            tx_en,
    input  logic            cts_line,
    input  logic            irq_ack,
    output logic            txd,
    output logic            buf_empty,
    output logic            shift_empty,
    output logic            irq
);
    typedef struct packed {
        logic [DIV_W-1:0]    div;
        fmt_t                fmt;
        logic [DATA_MAX-1:0] hold;
        logic                full;
        logic                irq;
    } st_t;

    st_t  st_d, st_q;
    logic cts_s;
    logic tick;
    logic busy;
    logic frame_end;
    logic load;
    logic cts_ok;
    logic set_evt;
    logic cts_en_w;

    stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_line),
        .q     (cts_s)
    );

    stx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .clk_en (clk_en),
        .div    (st_q.div),
        .tick   (tick)
    );

    stx_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tick      (tick),
        .data      (st_q.hold),
        .fmt       (st_q.fmt),
        .txd       (txd),
        .busy      (busy),
        .frame_end (frame_end)
    );

    always_comb begin
        cts_ok  = !st_q.fmt.cts_en || !cts_s;
        load    = st_q.full && tx_en && cts_ok && (!busy || frame_end);
        set_evt = st_q.fmt.irq_done ? (frame_end && !load) : load;

        st_d      = st_q;
        st_d.full = st_q.full && !load;
        if (wr_en && wr_cfg) begin
            st_d.div = wr_data[DIV_W-1:0];
            st_d.fmt = fmt_t'(wr_data[DIV_W +: FMT_W]);
        end
        if (wr_en && !wr_cfg) begin
            st_d.hold = wr_data[DATA_MAX-1:0];
            st_d.full = 1'b1;
        end
        st_d.irq = set_evt || (st_q.irq && !irq_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div  <= '0;
            st_q.fmt  <= '0;
            st_q.hold <= '0;
            st_q.full <= 1'b0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cts_en_w    = st_q.fmt.cts_en;
    assign buf_empty   = !st_q.full;
    assign shift_empty = !busy;
    assign irq         = st_q.irq;
endmodule

// File: rtl/stx_core_chk.sv
module stx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic wr_en,
    input logic wr_cfg,
    input logic tx_en,
    input logic irq_ack,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic irq,
    input logic cts_en,
    input logic cts_hold
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    a_r2_no_enable_no_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !shift_empty) |=> $stable(txd));

    a_r3_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);

    a_r5_write_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_cfg) |=> !buf_empty);

    a_r7_cts_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && cts_en && cts_hold) |=> shift_empty);

    a_r9_disable_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !tx_en) |=> shift_empty);

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
endmodule

bind stx_core stx_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .wr_en       (wr_en),
    .wr_cfg      (wr_cfg),
    .tx_en       (tx_en),
    .irq_ack     (irq_ack),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .irq         (irq),
    .cts_en      (cts_en_w),
    .cts_hold    (cts_s)
);

// File: tb/stx_core_bench.sv
module stx_core_bench;
    localparam int CLK_P = 10;
    localparam int WR_W  = 14;
    localparam int WD    = 100000;
    localparam int NVEC  = 6;
    // fields: [12] nine, [11] parity on, [10] odd, [9] two stop, [8:0] data
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
        {1'b0, 1'b1, 1'b0, 1'b0, 9'h03C},
        {1'b0, 1'b1, 1'b1, 1'b1, 9'h081},
        {1'b1, 1'b0, 1'b0, 1'b1, 9'h1F0},
        {1'b1, 1'b1, 1'b0, 1'b0, 9'h101},
        {1'b1, 1'b1, 1'b1, 1'b1, 9'h0FF}
    };

    logic clk = 1'b0;
    logic rst_n, clk_en, wr_en, wr_cfg, tx_en, cts_line, irq_ack;
    logic [WR_W-1:0] wr_data;
    logic txd, buf_empty, shift_empty, irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_P / 2) clk = ~clk;

    stx_core u_stx_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .wr_cfg(wr_cfg),
        .wr_data(wr_data), .tx_en(tx_en), .cts_line(cts_line), .irq_ack(irq_ack),
        .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_frame(input logic nine, input logic pe,
                                              input logic po, input logic ts,
                                              input logic [8:0] d);
        logic [12:0] f = '0;
        int n = 1;
        int ones = 0;
        for (int i = 0; i < 8; i++) begin
            f = f | (13'((d >> i) & 9'd1) << n);
            ones += int'((d >> i) & 9'd1);
            n++;
        end
        if (nine) begin
            f = f | (13'(d[8]) << n);
            ones += int'(d[8]);
            n++;
        end
        if (pe) begin
            f = f | (13'(((ones % 2) == 1) ^ po) << n);
            n++;
        end
        f = f | (13'd1 << n);
        n++;
        if (ts) f = f | (13'd1 << n);
        return f;
    endfunction

    function automatic int frame_len(input logic nine, input logic pe, input logic ts);
        return 10 + int'(nine) + int'(pe) + int'(ts);
    endfunction

    task automatic cfg_write(input logic [7:0] div, input logic nine, input logic pe,
                             input logic po, input logic ts, input logic ce,
                             input logic isel);
        wr_en = 1'b1; wr_cfg = 1'b1;
        wr_data = {isel, ce, ts, po, pe, nine, div};
        @(negedge clk);
        wr_en = 1'b0; wr_cfg = 1'b0;
    endtask

    task automatic data_write(input logic [8:0] d);
        wr_en = 1'b1; wr_cfg = 1'b0;
        wr_data = {5'b0, d};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start(output int w);
        w = 0;
        while (txd !== 1'b0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        while (shift_empty !== 1'b1 && k < 20000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic capture(input int nb, input int per, input bit skip,
                           output logic [12:0] bits, output int w);
        w = 0;
        if (!skip) wait_start(w);
        repeat (per / 2) @(negedge clk);
        bits = 13'(txd);
        for (int i = 1; i < nb; i++) begin
            repeat (per) @(negedge clk);
            bits = bits | (13'(txd) << i);
        end
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=finish", WD);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [12:0] bits;
        int w;
        logic t0;
        rst_n = 1'b0; clk_en = 1'b1; wr_en = 1'b0; wr_cfg = 1'b0; wr_data = '0;
        tx_en = 1'b1; cts_line = 1'b0; irq_ack = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd idle", 32'(txd), 32'd1);
        chk("R1 buf_empty", 32'(buf_empty), 32'd1);
        chk("R1 shift_empty", 32'(shift_empty), 32'd1);
        chk("R1 irq", 32'(irq), 32'd0);

        // table of frame formats (R3, R4, R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            logic [12:0] e;
            int nb;
            e = exp_frame(VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8:0]);
            nb = frame_len(VEC[v][12], VEC[v][11], VEC[v][9]);
            cfg_write(8'd0, VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9], 1'b0, 1'b0);
            data_write(VEC[v][8:0]);
            capture(nb, 16, 1'b0, bits, w);
            chk($sformatf("%s vec%0d frame", VEC[v][11] ? "R4" : "R3", v), 32'(bits), 32'(e));
            chk($sformatf("R5 vec%0d start delay", v), 32'(w), 32'd1);
            repeat (10) @(negedge clk);
            chk($sformatf("R6 vec%0d idle after", v), 32'(shift_empty), 32'd1);
            chk($sformatf("R1 vec%0d line high", v), 32'(txd), 32'd1);
        end

        // R2: divisor 2 gives a 48-cycle bit
        cfg_write(8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        data_write(9'h055);
        wait_start(w);
        w = 0;
        while (txd === 1'b0 && w < 1000) begin
            @(negedge clk);
            w++;
        end
        chk("R2 start bit length div2", 32'(w), 32'd48);
        wait_idle();

        // R2: clk_en low freezes the frame
        cfg_write(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        data_write(9'h00F);
        wait_start(w);
        repeat (40) @(negedge clk);
        clk_en = 1'b0;
        t0 = txd;
        repeat (200) @(negedge clk);
        chk("R2 frozen txd", 32'(txd), 32'(t0));
        chk("R2 frozen busy", 32'(shift_empty), 32'd0);
        clk_en = 1'b1;
        wait_idle();
        chk("R2 resumes to idle", 32'(shift_empty), 32'd1);

        // R5 / R6: double buffering, back-to-back frames
        data_write(9'h012);
        data_write(9'h034);
        chk("R5 second byte queued", 32'(buf_empty), 32'd0);
        chk("R6 busy during frame", 32'(shift_empty), 32'd0);
        capture(10, 16, 1'b0, bits, w);
        chk("R5 first frame", 32'(bits), 32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h012)));
        chk("R5 first start delay", 32'(w), 32'd0);
        chk("R5 buffer full during first", 32'(buf_empty), 32'd0);
        capture(10, 16, 1'b0, bits, w);
        chk("R5 no gap between frames", 32'(w), 32'd8);
        chk("R5 second frame", 32'(bits), 32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h034)));
        chk("R5 buffer empty again", 32'(buf_empty), 32'd1);
        repeat (4) @(negedge clk);
        chk("R6 still busy in stop bit", 32'(shift_empty), 32'd0);
        repeat (6) @(negedge clk);
        chk("R6 idle after stop bit", 32'(shift_empty), 32'd1);

        // R7: clear-to-send hold-off
        cts_line = 1'b1;
        cfg_write(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        data_write(9'h05A);
        repeat (50) @(negedge clk);
        chk("R7 held while idle", 32'(shift_empty), 32'd1);
        chk("R7 line high while held", 32'(txd), 32'd1);
        chk("R7 byte waiting", 32'(buf_empty), 32'd0);
        cts_line = 1'b0;
        wait_start(w);
        chk("R7 release delay", 32'(w), 32'd3);
        cts_line = 1'b1;
        data_write(9'h0C3);
        capture(10, 16, 1'b1, bits, w);
        chk("R7 frame in flight completes", 32'(bits),
            32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h05A)));
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R7 held at boundary", 32'(shift_empty), 32'd1);
        chk("R7 byte held in buffer", 32'(buf_empty), 32'd0);
        cts_line = 1'b0;
        wait_start(w);
        chk("R7 boundary release delay", 32'(w), 32'd3);
        capture(10, 16, 1'b1, bits, w);
        chk("R7 held frame", 32'(bits), 32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h0C3)));
        wait_idle();

        // R8: flow control off ignores the line
        cfg_write(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cts_line = 1'b1;
        repeat (3) @(negedge clk);
        data_write(9'h077);
        capture(10, 16, 1'b0, bits, w);
        chk("R8 start delay", 32'(w), 32'd1);
        chk("R8 frame", 32'(bits), 32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h077)));
        cts_line = 1'b0;
        wait_idle();

        // R9: transmit enable
        tx_en = 1'b0;
        data_write(9'h011);
        repeat (40) @(negedge clk);
        chk("R9 no start while disabled", 32'(shift_empty), 32'd1);
        chk("R9 line high while disabled", 32'(txd), 32'd1);
        tx_en = 1'b1;
        wait_start(w);
        chk("R9 enable start delay", 32'(w), 32'd1);
        data_write(9'h022);
        tx_en = 1'b0;
        capture(10, 16, 1'b1, bits, w);
        chk("R9 frame finishes", 32'(bits), 32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h011)));
        wait_idle();
        repeat (60) @(negedge clk);
        chk("R9 next not started", 32'(shift_empty), 32'd1);
        chk("R9 next still queued", 32'(buf_empty), 32'd0);
        tx_en = 1'b1;
        wait_start(w);
        chk("R9 queued start delay", 32'(w), 32'd1);
        capture(10, 16, 1'b1, bits, w);
        chk("R9 queued frame", 32'(bits), 32'(exp_frame(1'b0, 1'b0, 1'b0, 1'b0, 9'h022)));
        wait_idle();

        // R10: interrupt source select
        ack();
        chk("R10 ack clears", 32'(irq), 32'd0);
        data_write(9'h003);
        wait_start(w);
        chk("R10 set on buffer transfer", 32'(irq), 32'd1);
        ack();
        chk("R10 ack clears after transfer", 32'(irq), 32'd0);
        wait_idle();
        chk("R10 not set on completion when bit13=0", 32'(irq), 32'd0);
        cfg_write(8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        data_write(9'h004);
        wait_start(w);
        chk("R10 not set on transfer when bit13=1", 32'(irq), 32'd0);
        wait_idle();
        chk("R10 set on completion", 32'(irq), 32'd1);
        repeat (20) @(negedge clk);
        chk("R10 sticky", 32'(irq), 32'd1);
        ack();
        chk("R10 ack clears completion", 32'(irq), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule